// File: doc/BRIEF.md
# Fuse Array Access Sequencer

This block sits between a register bus and a one-time-programmable fuse macro. Software hands it a single operation: either read one 32-bit fuse word, or burn one fuse bit. The block then drives the macro's chip-select, program-enable, load, strobe and address pins over time. Every pin has its own start cycle and hold length. Two full sets of these timings are kept, one for programming and one for reading. When the sequence ends, a read result is captured into a data register and a completion flag is raised. That flag can drive an interrupt line.

Programming is bit-serial at the software level. To burn bit n of word w, software issues one program operation at fuse address w + 32·n. A mode bit lets software bypass the sequencer and drive the macro pins directly from a control register.

Register map, as byte offsets on the bus:

| Offset | Register |
|--------|----------|
| 0x00 | mode |
| 0x04 | interrupt enable |
| 0x08 | interrupt status |
| 0x0C | direct pin control |
| 0x10 | read data |
| 0x14 | operation control |
| 0x40 + 4·i | program timing |
| 0x60 + 4·i | read timing |

In the timing registers, the signal index i is 0 for chip-select, 1 for program-enable, 2 for load, 3 for address and 4 for strobe.

Top module: `fuse_access_ctrl`

## Requirements
- R1: After reset, the macro pins are idle: chip-select high, program-enable high, load low, strobe low, address 0. The mode register reads 0. The status register reads 0. Program timing registers read {setup,length} = {1,241} for indices 0 to 3 and {2,240} for index 4. Read timing registers read {1,4} for indices 0 to 3 and {2,3} for index 4. In each timing register, setup is bits 31:16 and length is bits 15:0.
- R2: A write to the operation control register launches an operation when all of these hold: the mode is automatic (mode bit 0 = 0), the block is idle, bit 0 of the write is 1, and the stored bit 0 is 0. Bit 1 of the write selects read (1) or program (0). Bits 25:16 carry the 10-bit fuse address.
- R3: Count the cycle after the launching edge as cycle 0. Signal i is active in cycles setup_i through setup_i + len_i − 1, with a length of 0 counted as 1. The timing set used is the one selected by the operation type.
- R4: Chip-select and program-enable are active low. Program-enable goes active only in program operations, and load only in read operations. The address pins carry the operation address only while the address window is active, and 0 otherwise. Outside an operation, the pins are idle.
- R5: The operation lasts max_i(setup_i + effective length_i) cycles. Status bit 0 is set on the edge that ends the last cycle. The irq output equals the OR of the status bits ANDed with the enable bits.
- R6: In a read, the read data register captures the macro's data output on the edge that ends the last active strobe cycle.
- R7: Writing a 1 to status bit 0 clears it, so writing 0x07 clears every flag. Status bits 2:1 read as 0.
- R8: While an operation is in progress, writes to the operation control register are ignored. A start bit that is still stored as 1 does not launch a new operation.
- R9: With mode bit 0 = 1, the pins follow the direct control register as raw levels: bit 0 chip-select, bit 1 strobe, bit 2 load, bit 3 program-enable, bits 25:16 address. Launch writes have no effect in this mode.
- R10: While an operation is in progress, writes to the timing registers are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | controller clock |
| rst | input | 1 | synchronous active-high reset |
| bus_we | input | 1 | register write strobe |
| bus_waddr | input | 8 | register write byte offset |
| bus_wdata | input | 32 | register write data |
| bus_raddr | input | 8 | register read byte offset |
| bus_rdata | output | 32 | register read data (combinational) |
| fuse_csb | output | 1 | macro chip select, active low |
| fuse_pgenb | output | 1 | macro program enable, active low |
| fuse_load | output | 1 | macro sense load |
| fuse_strobe | output | 1 | macro strobe |
| fuse_addr | output | 10 | macro bit/word address |
| fuse_dout | input | 32 | macro read data |
| irq | output | 1 | masked completion interrupt |

## Verification
The assertions assume two things about the inputs:
- The bus applies at most one register write per cycle.
- The macro's data output is only sampled when the sequencer says so.

They make no assumption about the timing values, because any setup or length, zero included, must give a consistent pin picture.

The stimulus keeps to small random setups (0 to 4) and lengths (0 to 5) so that many operations fit in the run. Default timings are exercised directly. Every launch comes from an idle, automatic-mode state with the stored start bit cleared, except in the cases that deliberately test rejection.

// File: rtl/fac_pkg.sv
package fac_pkg;
    localparam int FA_W   = 10;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 16;
    localparam int NSIG   = 5;
    localparam int OFF_W  = 8;

    // signal index order of the timing tables
    localparam int SG_CSB    = 0;
    localparam int SG_PGENB  = 1;
    localparam int SG_LOAD   = 2;
    localparam int SG_ADDR   = 3;
    localparam int SG_STROBE = 4;

    localparam int OFF_MODE  = 'h00;
    localparam int OFF_IEN   = 'h04;
    localparam int OFF_ISTAT = 'h08;
    localparam int OFF_UCTRL = 'h0C;
    localparam int OFF_DOUT  = 'h10;
    localparam int OFF_ACTRL = 'h14;
    localparam int OFF_TPROG = 'h40;
    localparam int OFF_TREAD = 'h60;

    typedef enum logic {OP_PROG = 1'b0, OP_READ = 1'b1} op_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] len;
    } win_t;

    typedef struct packed {
        logic            csb_n;
        logic            pgenb_n;
        logic            load;
        logic            strobe;
        logic [FA_W-1:0] addr;
    } pins_t;

    localparam pins_t PINS_IDLE = '{csb_n: 1'b1, pgenb_n: 1'b1, load: 1'b0,
                                    strobe: 1'b0, addr: '0};

    function automatic win_t dflt_win(input logic rd, input int sig);
        win_t w;
        w.setup = (sig == SG_STROBE) ? CNT_W'(2) : CNT_W'(1);
        if (rd) w.len = (sig == SG_STROBE) ? CNT_W'(3) : CNT_W'(4);
        else    w.len = (sig == SG_STROBE) ? CNT_W'(240) : CNT_W'(241);
        return w;
    endfunction

    // first cycle after the window; zero length behaves as one cycle
    function automatic logic [CNT_W:0] win_end(input win_t w);
        logic [CNT_W:0] l;
        l = (w.len == '0) ? (CNT_W+1)'(1) : {1'b0, w.len};
        return {1'b0, w.setup} + l;
    endfunction

    function automatic logic in_win(input logic [CNT_W:0] c, input win_t w);
        return (c >= {1'b0, w.setup}) && (c < win_end(w));
    endfunction
endpackage

// File: rtl/fac_regs.sv
module fac_regs
    import fac_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_we,
    input  logic [OFF_W-1:0]        bus_waddr,
    input  logic [WORD_W-1:0]       bus_wdata,
    input  logic [OFF_W-1:0]        bus_raddr,
    output logic [WORD_W-1:0]       bus_rdata,
    input  logic                    seq_busy,
    input  logic                    seq_done,
    input  logic                    cap_en,
    input  logic [WORD_W-1:0]       cap_data,
    output logic                    user_mode,
    output pins_t                   user_pins,
    output logic                    launch,
    output logic                    launch_rd,
    output logic [FA_W-1:0]         launch_addr,
    output win_t [NSIG-1:0]         prog_tim,
    output win_t [NSIG-1:0]         read_tim,
    output logic                    irq
);
    localparam logic [OFF_W-1:0] A_MODE  = OFF_W'(OFF_MODE);
    localparam logic [OFF_W-1:0] A_IEN   = OFF_W'(OFF_IEN);
    localparam logic [OFF_W-1:0] A_ISTAT = OFF_W'(OFF_ISTAT);
    localparam logic [OFF_W-1:0] A_UCTRL = OFF_W'(OFF_UCTRL);
    localparam logic [OFF_W-1:0] A_DOUT  = OFF_W'(OFF_DOUT);
    localparam logic [OFF_W-1:0] A_ACTRL = OFF_W'(OFF_ACTRL);

    logic              mode_q;
    logic [2:0]        ien_q;
    logic              stat_q;
    pins_t             uctrl_q;
    logic [WORD_W-1:0] dout_q;
    logic              go_q;
    logic              op_q;
    logic [FA_W-1:0]   aaddr_q;

    logic w_mode, w_ien, w_istat, w_uctrl, w_actrl;
    assign w_mode  = bus_we && (bus_waddr == A_MODE);
    assign w_ien   = bus_we && (bus_waddr == A_IEN);
    assign w_istat = bus_we && (bus_waddr == A_ISTAT);
    assign w_uctrl = bus_we && (bus_waddr == A_UCTRL);
    assign w_actrl = bus_we && (bus_waddr == A_ACTRL);

    // a launch needs a 0->1 change of the stored start bit in automatic mode
    assign launch      = w_actrl && !seq_busy && !mode_q && bus_wdata[0] && !go_q;
    assign launch_rd   = bus_wdata[1];
    assign launch_addr = bus_wdata[16 +: FA_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 1'b0;
            ien_q   <= '0;
            stat_q  <= 1'b0;
            uctrl_q <= PINS_IDLE;
            dout_q  <= '0;
            go_q    <= 1'b0;
            op_q    <= 1'b0;
            aaddr_q <= '0;
        end else begin
            if (w_mode) mode_q <= bus_wdata[0];
            if (w_ien)  ien_q  <= bus_wdata[2:0];
            if (seq_done)                     stat_q <= 1'b1;
            else if (w_istat && bus_wdata[0]) stat_q <= 1'b0;
            if (w_uctrl) begin
                uctrl_q.csb_n   <= bus_wdata[0];
                uctrl_q.strobe  <= bus_wdata[1];
                uctrl_q.load    <= bus_wdata[2];
                uctrl_q.pgenb_n <= bus_wdata[3];
                uctrl_q.addr    <= bus_wdata[16 +: FA_W];
            end
            if (cap_en) dout_q <= cap_data;
            if (w_actrl && !seq_busy) begin
                go_q    <= bus_wdata[0];
                op_q    <= bus_wdata[1];
                aaddr_q <= bus_wdata[16 +: FA_W];
            end
        end
    end

    for (genvar i = 0; i < NSIG; i++) begin : g_tim
        localparam logic [OFF_W-1:0] A_P = OFF_W'(OFF_TPROG + 4*i);
        localparam logic [OFF_W-1:0] A_R = OFF_W'(OFF_TREAD + 4*i);
        always_ff @(posedge clk) begin
            if (rst) begin
                prog_tim[i] <= dflt_win(1'b0, i);
                read_tim[i] <= dflt_win(1'b1, i);
            end else if (bus_we && !seq_busy) begin
                if (bus_waddr == A_P) prog_tim[i] <= win_t'(bus_wdata);
                if (bus_waddr == A_R) read_tim[i] <= win_t'(bus_wdata);
            end
        end
    end

    assign user_mode = mode_q;
    assign user_pins = uctrl_q;
    assign irq       = |({2'b00, stat_q} & ien_q);

    always_comb begin
        bus_rdata = '0;
        case (bus_raddr)
            A_MODE:  bus_rdata = {31'b0, mode_q};
            A_IEN:   bus_rdata = {29'b0, ien_q};
            A_ISTAT: bus_rdata = {31'b0, stat_q};
            A_UCTRL: bus_rdata = {6'b0, uctrl_q.addr, 12'b0, uctrl_q.pgenb_n,
                                  uctrl_q.load, uctrl_q.strobe, uctrl_q.csb_n};
            A_DOUT:  bus_rdata = dout_q;
            A_ACTRL: bus_rdata = {6'b0, aaddr_q, 14'b0, op_q, go_q};
            default: ;
        endcase
        for (int i = 0; i < NSIG; i++) begin
            if (bus_raddr == OFF_W'(OFF_TPROG + 4*i)) bus_rdata = prog_tim[i];
            if (bus_raddr == OFF_W'(OFF_TREAD + 4*i)) bus_rdata = read_tim[i];
        end
    end

    // R5: completion from the sequencer always leaves the flag set
    a_r5_done_sets_flag: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> stat_q);
    // R10: timing tables do not move under a running operation
    a_r10_timing_frozen: assert property (@(posedge clk) disable iff (rst)
        seq_busy |=> ($stable(prog_tim) && $stable(read_tim)));
    // R8: operation control is locked while busy
    a_r8_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
        seq_busy |=> ($stable(go_q) && $stable(op_q) && $stable(aaddr_q)));
endmodule

// File: rtl/fac_seq.sv
module fac_seq
    import fac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              launch_rd,
    input  logic [FA_W-1:0]   launch_addr,
    input  win_t [NSIG-1:0]   prog_tim,
    input  win_t [NSIG-1:0]   read_tim,
    output logic              busy,
    output logic              done,
    output logic              cap_en,
    output pins_t             pins
);
    logic            busy_q;
    logic [CNT_W:0]  cnt_q;
    op_e             op_q;
    logic [FA_W-1:0] addr_q;

    win_t [NSIG-1:0] tim;
    logic [NSIG-1:0] act;
    logic [CNT_W:0]  end_max;

    for (genvar i = 0; i < NSIG; i++) begin : g_win
        assign tim[i] = (op_q == OP_READ) ? read_tim[i] : prog_tim[i];
        assign act[i] = busy_q && in_win(cnt_q, tim[i]);
    end

    always_comb begin
        end_max = '0;
        for (int i = 0; i < NSIG; i++)
            if (win_end(tim[i]) > end_max) end_max = win_end(tim[i]);
    end

    assign busy   = busy_q;
    assign done   = busy_q && (cnt_q == end_max - 1'b1);
    assign cap_en = busy_q && (op_q == OP_READ) &&
                    (cnt_q == win_end(tim[SG_STROBE]) - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_PROG;
            addr_q <= '0;
        end else if (launch) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            op_q   <= launch_rd ? OP_READ : OP_PROG;
            addr_q <= launch_addr;
        end else if (busy_q) begin
            if (done) busy_q <= 1'b0;
            else      cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        pins.csb_n   = !act[SG_CSB];
        pins.pgenb_n = !(act[SG_PGENB] && (op_q == OP_PROG));
        pins.load    = act[SG_LOAD] && (op_q == OP_READ);
        pins.strobe  = act[SG_STROBE];
        pins.addr    = act[SG_ADDR] ? addr_q : '0;
    end

    // R3: the cycle counter advances by one every busy cycle until the end
    a_r3_cnt_step: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done && !launch) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
    // R5: the last cycle returns the sequencer to idle
    a_r5_done_idles: assert property (@(posedge clk) disable iff (rst)
        (done && !launch) |=> !busy_q);
    // R2: a launch is only taken from idle
    a_r2_launch_idle: assert property (@(posedge clk) disable iff (rst)
        launch |-> !busy_q);
endmodule

// File: rtl/fac_pinmux.sv
module fac_pinmux
    import fac_pkg::*;
(
    input  logic  user_mode,
    input  pins_t auto_pins,
    input  pins_t user_pins,
    output pins_t pins
);
    assign pins = user_mode ? user_pins : auto_pins;
endmodule

// File: rtl/fuse_access_ctrl.sv
module fuse_access_ctrl
    import fac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [OFF_W-1:0]  bus_waddr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [OFF_W-1:0]  bus_raddr,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              fuse_csb,
    output logic              fuse_pgenb,
    output logic              fuse_load,
    output logic              fuse_strobe,
    output logic [FA_W-1:0]   fuse_addr,
    input  logic [WORD_W-1:0] fuse_dout,
    output logic              irq
);
    logic            user_mode, launch, launch_rd, seq_busy, seq_done, cap_en;
    logic [FA_W-1:0] launch_addr;
    win_t [NSIG-1:0] prog_tim, read_tim;
    pins_t           user_pins, auto_pins, pins;

    fac_regs u_regs (
        .clk(clk), .rst(rst),
        .bus_we(bus_we), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
        .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .seq_busy(seq_busy), .seq_done(seq_done),
        .cap_en(cap_en), .cap_data(fuse_dout),
        .user_mode(user_mode), .user_pins(user_pins),
        .launch(launch), .launch_rd(launch_rd), .launch_addr(launch_addr),
        .prog_tim(prog_tim), .read_tim(read_tim), .irq(irq)
    );

    fac_seq u_seq (
        .clk(clk), .rst(rst),
        .launch(launch), .launch_rd(launch_rd), .launch_addr(launch_addr),
        .prog_tim(prog_tim), .read_tim(read_tim),
        .busy(seq_busy), .done(seq_done), .cap_en(cap_en), .pins(auto_pins)
    );

    fac_pinmux u_mux (
        .user_mode(user_mode), .auto_pins(auto_pins),
        .user_pins(user_pins), .pins(pins)
    );

    assign fuse_csb    = pins.csb_n;
    assign fuse_pgenb  = pins.pgenb_n;
    assign fuse_load   = pins.load;
    assign fuse_strobe = pins.strobe;
    assign fuse_addr   = pins.addr;

    // R4: automatic mode with no operation leaves the macro idle
    a_r4_idle_pins: assert property (@(posedge clk) disable iff (rst)
        (!user_mode && !seq_busy) |->
        (fuse_csb && fuse_pgenb && !fuse_load && !fuse_strobe && fuse_addr == '0));
    // R4: sensing and burning are never requested together
    a_r4_load_pgenb_excl: assert property (@(posedge clk) disable iff (rst)
        !user_mode |-> !(fuse_load && !fuse_pgenb));
    // R6: capture happens inside a strobe pulse
    a_r6_cap_in_strobe: assert property (@(posedge clk) disable iff (rst)
        (cap_en && !user_mode) |-> fuse_strobe);
endmodule

// File: tb/fuse_access_ctrl_tb_top.sv
`timescale 1ns/100ps
module fuse_access_ctrl_tb_top;
    localparam int A_MODE = 'h00, A_IEN = 'h04, A_ISTAT = 'h08, A_UCTRL = 'h0C;
    localparam int A_DOUT = 'h10, A_ACTRL = 'h14, A_TP = 'h40, A_TR = 'h60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_waddr = '0, bus_raddr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        fuse_csb, fuse_pgenb, fuse_load, fuse_strobe, irq;
    logic [9:0]  fuse_addr;
    logic [31:0] fuse_dout;

    int total = 0, bad = 0;
    int ts[2][5], tl[2][5];
    bit ien_on = 0;
    logic [31:0] seed_mem[32], fuse_mem[32], exp_mem[32];

    always #2.5 clk = ~clk;

    fuse_access_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .fuse_csb(fuse_csb), .fuse_pgenb(fuse_pgenb), .fuse_load(fuse_load),
        .fuse_strobe(fuse_strobe), .fuse_addr(fuse_addr), .fuse_dout(fuse_dout),
        .irq(irq)
    );

    // behavioural fuse macro: word = addr[4:0], bit = addr[9:5]
    assign fuse_dout = (fuse_strobe && fuse_load) ? fuse_mem[fuse_addr[4:0]] : 32'h0;
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) fuse_mem[i] <= seed_mem[i];
        end else if (!fuse_csb && !fuse_pgenb && fuse_strobe) begin
            fuse_mem[fuse_addr[4:0]][fuse_addr[9:5]] <= 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_waddr = 8'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        bus_raddr = 8'(a);
        #1 v = bus_rdata;
    endtask

    function automatic int eff(input int l);
        return (l == 0) ? 1 : l;
    endfunction

    function automatic int seq_len(input bit r);
        int m = 0;
        for (int i = 0; i < 5; i++)
            if (ts[r][i] + eff(tl[r][i]) > m) m = ts[r][i] + eff(tl[r][i]);
        return m;
    endfunction

    task automatic exp_pins(input int k, input bit r, input int a,
                            output logic csb, pg, ld, st, output logic [9:0] ad);
        bit act[5];
        for (int i = 0; i < 5; i++)
            act[i] = (k >= ts[r][i]) && (k < ts[r][i] + eff(tl[r][i]));
        csb = !act[0];
        pg  = !(act[1] && !r);
        ld  = act[2] && r;
        st  = act[4];
        ad  = act[3] ? 10'(a) : 10'd0;
    endtask

    task automatic set_tim(input bit r, input int i, input int s, input int l);
        wr((r ? A_TR : A_TP) + 4*i, (32'(s) << 16) | 32'(l));
        ts[r][i] = s; tl[r][i] = l;
    endtask

    // one full operation with a cycle-by-cycle pin comparison (R2, R3, R4)
    task automatic run_access(input bit r, input int a, input string req);
        int n, capk, errs;
        logic csb, pg, ld, st;
        logic [9:0] ad;
        logic [31:0] exp_d, v;
        n = seq_len(r); capk = ts[r][4] + eff(tl[r][4]) - 1; errs = 0; exp_d = 0;
        wr(A_ACTRL, (32'(a) << 16) | (32'(r) << 1) | 32'd1);
        for (int k = 0; k < n + 2; k++) begin
            exp_pins(k, r, a, csb, pg, ld, st, ad);
            if (fuse_csb !== csb || fuse_pgenb !== pg || fuse_load !== ld ||
                fuse_strobe !== st || fuse_addr !== ad) errs++;
            if (r && k == capk) exp_d = (ld && st) ? exp_mem[ad[4:0]] : 32'h0;
            if (!csb && !pg && st) exp_mem[ad[4:0]][ad[9:5]] = 1'b1;
            @(negedge clk);
        end
        check(errs == 0, req, "pin trace mismatches (R3/R4)", errs, 0);
        rd(A_ISTAT, v);
        check(v == 32'd1, "R5", "finish flag", v, 1);
        check(irq == ien_on, "R5", "irq level", irq, ien_on);
        if (r) begin
            rd(A_DOUT, v);
            check(v == exp_d, "R6", "read data", v, exp_d);
        end
        wr(A_ACTRL, 32'd0);
        wr(A_ISTAT, 32'h7);
    endtask

    task automatic prog_word(input int w, input logic [31:0] val);
        for (int n = 0; n < 32; n++)
            if (val[n]) run_access(1'b0, w + 32*n, "R2");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int w;
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) begin
            seed_mem[i] = $urandom & $urandom;
            exp_mem[i]  = seed_mem[i];
        end
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < 5; i++) begin
                ts[r][i] = (i == 4) ? 2 : 1;
                tl[r][i] = r ? ((i == 4) ? 3 : 4) : ((i == 4) ? 240 : 241);
            end
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        check(fuse_csb && fuse_pgenb && !fuse_load && !fuse_strobe && fuse_addr == 0,
              "R1", "idle pins", {fuse_csb, fuse_pgenb, fuse_load, fuse_strobe}, 4'hC);
        rd(A_MODE, v);  check(v == 0, "R1", "mode reset", v, 0);
        rd(A_ISTAT, v); check(v == 0, "R1", "status reset", v, 0);
        rd(A_TP, v);      check(v == {16'd1, 16'd241}, "R1", "prog csb timing", v, {16'd1, 16'd241});
        rd(A_TP + 16, v); check(v == {16'd2, 16'd240}, "R1", "prog strobe timing", v, {16'd2, 16'd240});
        rd(A_TR + 4, v);  check(v == {16'd1, 16'd4}, "R1", "read pgenb timing", v, {16'd1, 16'd4});
        rd(A_TR + 16, v); check(v == {16'd2, 16'd3}, "R1", "read strobe timing", v, {16'd2, 16'd3});

        // default timings: read, program one bit, read back
        wr(A_IEN, 32'h1); ien_on = 1;
        run_access(1'b1, 5, "R3");
        run_access(1'b0, 5 + 32*7, "R4");
        run_access(1'b1, 5, "R6");
        rd(A_DOUT, v);
        check(v[7] == 1'b1, "R6", "burned bit visible", v[7], 1);

        // R7: clear on write of 0x07
        wr(A_ACTRL, 32'h3);
        repeat (8) @(negedge clk);
        wr(A_ACTRL, 32'h0);
        rd(A_ISTAT, v); check(v == 1, "R5", "flag before clear", v, 1);
        wr(A_ISTAT, 32'h7);
        rd(A_ISTAT, v); check(v == 0, "R7", "flag after clear", v, 0);
        check(irq == 0, "R7", "irq after clear", irq, 0);

        // zero lengths count as one cycle (R3)
        for (int i = 0; i < 5; i++) set_tim(1'b1, i, i % 2, 0);
        run_access(1'b1, 9, "R3");

        // random timings and operations
        for (int it = 0; it < 24; it++) begin
            for (int r = 0; r < 2; r++)
                for (int i = 0; i < 5; i++)
                    set_tim(r[0], i, $urandom_range(0, 4), $urandom_range(0, 5));
            w = $urandom_range(0, 31);
            if (it % 2 == 0) prog_word(w, $urandom & $urandom & $urandom);
            run_access(1'b1, w, "R3");
        end

        // R8 / R10: writes during an operation
        for (int i = 0; i < 5; i++) set_tim(1'b1, i, (i == 4) ? 2 : 1, (i == 4) ? 30 : 4);
        wr(A_ACTRL, (32'd3 << 16) | 32'h3);
        wr(A_ACTRL, (32'd9 << 16) | 32'h3);
        wr(A_TR, 32'hDEAD_BEEF);
        for (int c = 0; c < 100; c++) begin
            rd(A_ISTAT, v);
            if (v[0]) break;
        end
        rd(A_ACTRL, v); check(v == ((32'd3 << 16) | 32'h3), "R8", "control locked", v, (32'd3 << 16) | 32'h3);
        rd(A_TR, v);    check(v == {16'd1, 16'd4}, "R10", "timing locked", v, {16'd1, 16'd4});
        wr(A_ISTAT, 32'h7);
        wr(A_ACTRL, (32'd9 << 16) | 32'h3);
        begin
            int e = 0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (!fuse_csb || fuse_strobe) e++;
            end
            check(e == 0, "R8", "no relaunch with start still set", e, 0);
        end
        rd(A_ISTAT, v); check(v == 0, "R8", "no finish without launch", v, 0);
        wr(A_ACTRL, 32'h0);

        // R9: direct pin control
        wr(A_MODE, 32'h1);
        wr(A_UCTRL, (32'h2A5 << 16) | 32'hE);
        @(negedge clk);
        check({fuse_pgenb, fuse_load, fuse_strobe, fuse_csb} == 4'hE && fuse_addr == 10'h2A5,
              "R9", "user pins A", {fuse_pgenb, fuse_load, fuse_strobe, fuse_csb}, 4'hE);
        wr(A_UCTRL, (32'h011 << 16) | 32'h9);
        wr(A_ACTRL, 32'h3);
        repeat (20) @(negedge clk);
        check({fuse_pgenb, fuse_load, fuse_strobe, fuse_csb} == 4'h9 && fuse_addr == 10'h011,
              "R9", "user pins B during launch attempt", {fuse_pgenb, fuse_load, fuse_strobe, fuse_csb}, 4'h9);
        rd(A_ISTAT, v); check(v == 0, "R9", "no operation in user mode", v, 0);
        wr(A_MODE, 32'h0);
        @(negedge clk);
        check(fuse_csb && fuse_pgenb && !fuse_load && !fuse_strobe && fuse_addr == 0,
              "R4", "idle after leaving user mode", {fuse_csb, fuse_pgenb, fuse_load, fuse_strobe}, 4'hC);
        wr(A_ACTRL, 32'h0);

        // R5: irq masked
        wr(A_IEN, 32'h0); ien_on = 0;
        run_access(1'b1, 17, "R5");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule